// File: doc/BRIEF.md
# Instruction Fetch Cycle Sequencer

This block sets the timing of every machine cycle in a small 16-bit processor. Each clock cycle is split into eight pulse slots, numbered 0 to 7. A machine cycle starts with a fetch phase, which always takes three clock cycles. In the first, the instruction pointer (register 0) is loaded into the storage address register. In the second, the addressed word is loaded into the 16-bit operation register. In the third, the pointer, advanced by two, is written back to register 0. An execution phase of one to three clock cycles follows. Its length comes from the decode logic.

The sequencer drives one-hot indicators for the phase, the cycle within the phase and the pulse slot. It also drives three register strobes, and a flag that limits storage addressing to writable storage during execution. A halt input stops the sequencer cleanly at the start of a clock cycle. The ALU and the instruction decoder sit outside this block.

The sequencer is a six-state machine: `ST_F1`, `ST_F2`, `ST_F3` (fetch cycles) and `ST_E1`, `ST_E2`, `ST_E3` (execution cycles). A state changes only on the edge that ends pulse slot 7. The transitions are:

- `T_FETCH_STEP` (F1→F2, F2→F3).
- `T_ENTER_EXEC` (F3→E1, where the execution length is captured).
- `T_EXEC_STEP` (E1→E2 when the length is at least 2, E2→E3 when the length is 3).
- `T_NEXT_INSTR` (the last execution cycle, E1, E2 or E3, goes to F1).

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low and after its release, the sequencer sits in fetch cycle 1, slot 0. This means `pulse_oh`=0x01, `phase_oh`=2'b01 and `cycle_oh`=3'b001, with every strobe low and `rws_only` low.
- R2: `pulse_oh` is always one-hot, with bit k meaning slot k. It advances one slot per clock and wraps from slot 7 to slot 0.
- R3: `phase_oh` bit 0 means fetch and bit 1 means execute. `cycle_oh` bit k means cycle k+1 of the current phase. The fetch phase always runs three cycles, in the order 1, 2, 3, and each cycle ends after slot 7.
- R4: `sar_load` is high only in slot 7 of fetch cycle 1.
- R5: `opreg_load` is high only in slot 7 of fetch cycle 2.
- R6: `reg0_write` is high only in slot 7 of fetch cycle 3.
- R7: The sequencer samples `exec_len` on the edge that ends slot 7 of fetch cycle 3. Code 1, 2 or 3 gives that many execution cycles, after which fetch cycle 1 starts again. A change in `exec_len` at any other time has no effect.
- R8: An `exec_len` code of 0 gives one execution cycle.
- R9: `rws_only` is high for every slot of the execution phase and low throughout the fetch phase.
- R10: While `halt` is high in slot 0, the sequencer stays in slot 0 of the same cycle and raises no strobe. A halt raised in slots 1 to 7 lets the current cycle finish, and the sequencer then stops at the next slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pulse-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Stops the sequencer at the next cycle boundary |
| exec_len | input | 2 | Execution cycle count from decode (0 or 1 = one cycle) |
| pulse_oh | output | 8 | One-hot pulse slot |
| phase_oh | output | 2 | One-hot phase: bit 0 fetch, bit 1 execute |
| cycle_oh | output | 3 | One-hot cycle within the phase |
| sar_load | output | 1 | Load register 0 into the address register |
| opreg_load | output | 1 | Load the fetched word into the operation register |
| reg0_write | output | 1 | Write the pointer plus two back to register 0 |
| rws_only | output | 1 | Only writable storage may be addressed |

## Verification
The bench changes `exec_len` across all four codes, including changes made in the middle of an execution phase. A design that samples the length late, or samples it more than once, would stretch or cut that phase. A design that decodes code 0 as zero cycles would skip execution entirely. Halts are raised both inside a cycle and exactly at slot 0. A design that freezes mid-cycle, or that repeats a slot-7 strobe while held, shows a wrong slot or a spurious `sar_load`, `opreg_load` or `reg0_write`. A reset applied in the middle of a run checks that the sequencer always restarts from fetch cycle 1.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
    localparam int LEN_W = 2;
    localparam int PHASES = 2;
    localparam int CYCLES = 3;

    typedef enum logic [2:0] {
        ST_F1,
        ST_F2,
        ST_F3,
        ST_E1,
        ST_E2,
        ST_E3
    } seq_state_t;
endpackage

// File: rtl/fs_pulse_ring.sv
module fs_pulse_ring #(
    parameter int PULSES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    output logic [PULSES-1:0] pulse_oh,
    output logic              slot_last
);
    localparam int PW = $clog2(PULSES);
    localparam logic [PW-1:0] LAST = PW'(PULSES - 1);

    logic [PW-1:0] slot_q;

    // Slot 0 is the only place where halt can hold the ring.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == '0 && halt) begin
            slot_q <= slot_q;
        end else if (slot_q == LAST) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + PW'(1);
        end
    end

    for (genvar i = 0; i < PULSES; i++) begin : g_slot
        assign pulse_oh[i] = (slot_q == PW'(i));
    end

    assign slot_last = pulse_oh[PULSES-1];
endmodule

// File: rtl/fs_cycle_fsm.sv
module fs_cycle_fsm
    import fetch_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic [LEN_W-1:0] exec_len,
    output seq_state_t       state_q
);
    seq_state_t       state_nxt;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_F1;
            len_q   <= LEN_W'(1);
        end else if (boundary) begin
            state_q <= state_nxt;
            if (state_q == ST_F3) begin
                len_q <= (exec_len == '0) ? LEN_W'(1) : exec_len;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_F1:   state_nxt = ST_F2;
            ST_F2:   state_nxt = ST_F3;
            ST_F3:   state_nxt = ST_E1;
            ST_E1:   state_nxt = (len_q >= LEN_W'(2)) ? ST_E2 : ST_F1;
            ST_E2:   state_nxt = (len_q == LEN_W'(3)) ? ST_E3 : ST_F1;
            ST_E3:   state_nxt = ST_F1;
            default: state_nxt = ST_F1;
        endcase
    end
endmodule

// File: rtl/fs_out_dec.sv
module fs_out_dec
    import fetch_seq_pkg::*;
(
    input  seq_state_t        state,
    input  logic              slot_last,
    output logic [PHASES-1:0] phase_oh,
    output logic [CYCLES-1:0] cycle_oh,
    output logic              sar_load,
    output logic              opreg_load,
    output logic              reg0_write,
    output logic              rws_only
);
    always_comb begin
        phase_oh   = 2'b01;
        cycle_oh   = 3'b001;
        sar_load   = 1'b0;
        opreg_load = 1'b0;
        reg0_write = 1'b0;
        rws_only   = 1'b0;
        unique case (state)
            ST_F1: sar_load = slot_last;
            ST_F2: begin
                cycle_oh   = 3'b010;
                opreg_load = slot_last;
            end
            ST_F3: begin
                cycle_oh   = 3'b100;
                reg0_write = slot_last;
            end
            ST_E1: begin
                phase_oh = 2'b10;
                rws_only = 1'b1;
            end
            ST_E2: begin
                phase_oh = 2'b10;
                cycle_oh = 3'b010;
                rws_only = 1'b1;
            end
            ST_E3: begin
                phase_oh = 2'b10;
                cycle_oh = 3'b100;
                rws_only = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter int PULSES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [1:0]        exec_len,
    output logic [PULSES-1:0] pulse_oh,
    output logic [1:0]        phase_oh,
    output logic [2:0]        cycle_oh,
    output logic              sar_load,
    output logic              opreg_load,
    output logic              reg0_write,
    output logic              rws_only
);
    logic       slot_last;
    seq_state_t state;

    fs_pulse_ring #(.PULSES(PULSES)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .pulse_oh  (pulse_oh),
        .slot_last (slot_last)
    );

    fs_cycle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (slot_last),
        .exec_len (exec_len),
        .state_q  (state)
    );

    fs_out_dec u_dec (
        .state      (state),
        .slot_last  (slot_last),
        .phase_oh   (phase_oh),
        .cycle_oh   (cycle_oh),
        .sar_load   (sar_load),
        .opreg_load (opreg_load),
        .reg0_write (reg0_write),
        .rws_only   (rws_only)
    );
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
    parameter int PULSES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic [PULSES-1:0] pulse_oh,
    input logic [1:0]        phase_oh,
    input logic [2:0]        cycle_oh,
    input logic              sar_load,
    input logic              opreg_load,
    input logic              reg0_write,
    input logic              rws_only
);
    a_r2_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pulse_oh) == 1);

    a_r2_pulse_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_oh[0] && halt) |=>
            pulse_oh == {$past(pulse_oh[PULSES-2:0]), $past(pulse_oh[PULSES-1])});

    a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_oh[0] && halt) |=> pulse_oh[0] && $stable(cycle_oh) && $stable(phase_oh));

    a_r3_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_oh) == 1 && $countones(cycle_oh) == 1);

    a_r3_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh[0] && !cycle_oh[2] && pulse_oh[PULSES-1]) |=>
            phase_oh[0] && cycle_oh == {$past(cycle_oh[1:0]), 1'b0});

    a_r3_fetch_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh[0] && cycle_oh[2] && pulse_oh[PULSES-1]) |=> phase_oh[1] && cycle_oh[0]);

    a_r7_exec_max: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh[1] && cycle_oh[2] && pulse_oh[PULSES-1]) |=> phase_oh[0] && cycle_oh[0]);

    a_r4_sar_slot: assert property (@(posedge clk) disable iff (!rst_n)
        sar_load |-> pulse_oh[PULSES-1] && phase_oh[0] && cycle_oh[0]);

    a_r5_opreg_slot: assert property (@(posedge clk) disable iff (!rst_n)
        opreg_load |-> pulse_oh[PULSES-1] && phase_oh[0] && cycle_oh[1]);

    a_r6_reg0_slot: assert property (@(posedge clk) disable iff (!rst_n)
        reg0_write |-> pulse_oh[PULSES-1] && phase_oh[0] && cycle_oh[2]);

    a_r9_rws_exec: assert property (@(posedge clk) disable iff (!rst_n)
        rws_only == phase_oh[1]);
endmodule

bind fetch_seq fetch_seq_chk #(.PULSES(PULSES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt       (halt),
    .pulse_oh   (pulse_oh),
    .phase_oh   (phase_oh),
    .cycle_oh   (cycle_oh),
    .sar_load   (sar_load),
    .opreg_load (opreg_load),
    .reg0_write (reg0_write),
    .rws_only   (rws_only)
);

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt = 1'b0;
    logic [1:0] exec_len = 2'd0;
    logic [7:0] pulse_oh;
    logic [1:0] phase_oh;
    logic [2:0] cycle_oh;
    logic       sar_load, opreg_load, reg0_write, rws_only;

    int checks = 0;
    int errors = 0;

    // Reference model: slot 0..7, cyc 0..2 = fetch 1..3, 3..5 = exec 1..3
    int m_slot = 0;
    int m_cyc  = 0;
    int m_len  = 1;
    bit m_zero = 0;

    always #10 clk = ~clk;

    fetch_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (halt),
        .exec_len   (exec_len),
        .pulse_oh   (pulse_oh),
        .phase_oh   (phase_oh),
        .cycle_oh   (cycle_oh),
        .sar_load   (sar_load),
        .opreg_load (opreg_load),
        .reg0_write (reg0_write),
        .rws_only   (rws_only)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_slot = 0;
            m_cyc  = 0;
            m_len  = 1;
            m_zero = 0;
        end else if (m_slot == 0 && halt) begin
            m_slot = 0;
        end else if (m_slot == 7) begin
            m_slot = 0;
            case (m_cyc)
                2: begin
                    m_zero = (exec_len == 2'd0);
                    m_len  = m_zero ? 1 : int'(exec_len);
                    m_cyc  = 3;
                end
                3: m_cyc = (m_len >= 2) ? 4 : 0;
                4: m_cyc = (m_len == 3) ? 5 : 0;
                5: m_cyc = 0;
                default: m_cyc = m_cyc + 1;
            endcase
        end else begin
            m_slot = m_slot + 1;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string t_slot, t_cyc;
        bit last;
        last   = (m_slot == 7);
        t_slot = !rst_n ? "R1" : (halt && m_slot == 0) ? "R10" : "R2";
        t_cyc  = !rst_n ? "R1" : (m_cyc < 3) ? "R3" : (m_zero ? "R8" : "R7");
        chk(t_slot, "pulse_oh", int'(pulse_oh), 1 << m_slot);
        chk(t_cyc, "phase_oh", int'(phase_oh), (m_cyc < 3) ? 1 : 2);
        chk(t_cyc, "cycle_oh", int'(cycle_oh), 1 << (m_cyc % 3));
        chk("R4", "sar_load", int'(sar_load), int'(m_cyc == 0 && last));
        chk("R5", "opreg_load", int'(opreg_load), int'(m_cyc == 1 && last));
        chk("R6", "reg0_write", int'(reg0_write), int'(m_cyc == 2 && last));
        chk("R9", "rws_only", int'(rws_only), int'(m_cyc >= 3));
    endtask

    initial begin
        int codes[8] = '{0, 3, 1, 2, 3, 0, 2, 1};
        repeat (3) @(negedge clk);
        compare_all();  // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();  // R1 first cycle after release
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            compare_all();
            exec_len = 2'(codes[(i / 53) % 8]);
            halt = (i >= 400 && i < 430) || (i >= 1203 && i < 1260) ||
                   (i >= 2000 && i < 2002) || (i >= 2201 && i < 2209);
            if (i == 2500) rst_n = 1'b0;
            if (i == 2503) rst_n = 1'b1;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule